// File: doc/BRIEF.md
# Serial-Bus Configuration Register Slave

This block is a two-wire serial-bus slave that gives a host access to a bank of 8-bit configuration registers, up to 32 of them, inside a clock-generator control section. The host reaches it at the 8-bit bus address 0xD2, where bit 0 is the read/write flag. The registers leave reset at fixed defaults, so the rest of the chip works whether or not the host ever writes them. Their contents are presented as one flat vector to the neighbouring control logic.

The first byte after the address is a command. When bit 7 of the command is set, the access is to one register, and bits [4:0] give its index. When bit 7 is clear, the access is a block transfer that always begins at register 0 and moves upward one register per byte. A block write carries a byte count from the host ahead of its data. A block read starts with a count byte from the slave, followed by register data. A per-bit read-only mask keeps identification and status fields at their default values.

Both bus lines are sampled in the system clock domain. The slave drives SDA only as an open-drain pull-down. It does not stretch the clock.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits are 1101001 (write 0xD2, read 0xD3). For any other address it drives nothing until the next START.
- R2: Single-register write: the host sends 0xD2, then a command with bit 7 = 1 whose bits [4:0] give the register index, then one data byte, MSB first. The slave acknowledges each byte, and the data lands in that register.
- R3: Single-register read: after the command the host issues a repeated START and 0xD3. The slave returns the register selected by command bits [4:0], MSB first, and the host ends with a not-acknowledge and a STOP.
- R4: Block write: a command byte of 0x00 is followed by a count byte and then data bytes. These bytes fill registers 0, 1, 2 and onward. Data bytes beyond the count are acknowledged but do not change any register.
- R5: Block read: a command of 0x00, a repeated START and 0xD3 make the slave return a count byte equal to the number of registers (18 by default), followed by registers 0, 1, 2 and onward. The slave keeps sending while the host acknowledges and stops on a not-acknowledge.
- R6: Read-only bits keep their defaults whatever is written: bits [3:0] of register 8 and bits [7:3] of register 15.
- R7: After reset the registers hold their defaults: register 2 = 0xFF, register 3 = 0x3F, register 8 = 0x08, all others 0x00.
- R8: A STOP at any point, including in the middle of a byte, returns the slave to idle. A partly received byte is never written.
- R9: An index at or beyond the number of registers is acknowledged. A write to it changes nothing, and a read from it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| cfg_q | output | NREG*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
After synchronization, a START or STOP check and an SCL falling edge can land in the same system-clock sample. This happens when the host changes SDA in the same cycle in which it drops SCL. If that coincident event were read as a START or STOP, the transfer would be torn apart.

The bench provokes it with a write in which every SDA change happens in the same cycle as the SCL fall. It then judges the outcome by two things: every byte must be acknowledged, and the addressed register must hold the sent value while no neighbouring register changes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam logic [6:0] SLV_ADDR7 = 7'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } stage_e;

  // power-up contents of register idx
  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      2:       return 8'hFF;
      3:       return 8'h3F;
      8:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // bits that software cannot change
  function automatic logic [7:0] reg_romask(int idx);
    case (idx)
      8:       return 8'h0F;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] merge_write(logic [7:0] old_v, logic [7:0] new_v,
                                             logic [7:0] ro);
    return (old_v & ro) | (new_v & ~ro);
  endfunction

  function automatic logic addr_hit(logic [7:0] b);
    return b[7:1] == SLV_ADDR7;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges count only while SCL stayed high across both samples
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  stage_e     stage_q;
  logic       ack_ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, ptr_q, remain_q;
  logic [4:0] off_q;
  logic       byte_mode_q, rw_q, ack_q, mack_q;
  logic       rx_stage, byte_done;

  assign rx_stage  = (stage_q == ST_ADDR) || (stage_q == ST_CMD) ||
                     (stage_q == ST_COUNT) || (stage_q == ST_WDATA);
  assign byte_done = rx_stage && !ack_ph_q && scl_fall && (bit_q == 4'd8);
  assign wr_en     = byte_done && (stage_q == ST_WDATA) && (remain_q != 8'd0);
  assign wr_idx    = ptr_q;
  assign wr_data   = sh_q;
  assign rd_idx    = byte_mode_q ? {3'b000, off_q} : ptr_q;
  assign sda_oe    = ack_q | ((stage_q == ST_RDATA) && !ack_ph_q && !tx_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= ST_IDLE;
      ack_ph_q    <= 1'b0;
      bit_q       <= '0;
      sh_q        <= '0;
      tx_q        <= 8'hFF;
      ptr_q       <= '0;
      remain_q    <= '0;
      off_q       <= '0;
      byte_mode_q <= 1'b0;
      rw_q        <= 1'b0;
      ack_q       <= 1'b0;
      mack_q      <= 1'b0;
    end else if (stop_det) begin
      stage_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      ack_q    <= 1'b0;
    end else if (start_det) begin
      stage_q  <= ST_ADDR;
      ack_ph_q <= 1'b0;
      ack_q    <= 1'b0;
      bit_q    <= '0;
    end else if (rx_stage) begin
      if (!ack_ph_q) begin
        if (scl_rise && bit_q != 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_s};
          bit_q <= bit_q + 4'd1;
        end
        if (byte_done) begin
          bit_q    <= '0;
          ack_ph_q <= 1'b1;
          ack_q    <= 1'b1;
          case (stage_q)
            ST_ADDR: begin
              if (!addr_hit(sh_q)) begin
                ack_q    <= 1'b0;
                ack_ph_q <= 1'b0;
                stage_q  <= ST_IGNORE;
              end else begin
                rw_q <= sh_q[0];
              end
            end
            ST_CMD: begin
              byte_mode_q <= sh_q[7];
              off_q       <= sh_q[4:0];
              if (sh_q[7]) begin
                ptr_q    <= {3'b000, sh_q[4:0]};
                remain_q <= 8'd1;
              end else begin
                ptr_q <= '0;
              end
            end
            ST_COUNT: remain_q <= sh_q;
            ST_WDATA: begin
              if (remain_q != 8'd0) begin
                ptr_q    <= ptr_q + 8'd1;
                remain_q <= remain_q - 8'd1;
              end
            end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        ack_ph_q <= 1'b0;
        ack_q    <= 1'b0;
        case (stage_q)
          ST_ADDR: begin
            if (rw_q) begin
              stage_q <= ST_RDATA;
              bit_q   <= '0;
              if (byte_mode_q) begin
                tx_q <= rd_data;
              end else begin
                tx_q  <= COUNT_BYTE;
                ptr_q <= '0;
              end
            end else begin
              stage_q <= ST_CMD;
            end
          end
          ST_CMD:   stage_q <= byte_mode_q ? ST_WDATA : ST_COUNT;
          ST_COUNT: stage_q <= ST_WDATA;
          default:  ;
        endcase
      end
    end else if (stage_q == ST_RDATA) begin
      if (!ack_ph_q) begin
        if (scl_fall) begin
          if (bit_q == 4'd7) begin
            ack_ph_q <= 1'b1;
            bit_q    <= '0;
          end else begin
            tx_q  <= {tx_q[6:0], 1'b0};
            bit_q <= bit_q + 4'd1;
          end
        end
      end else begin
        if (scl_rise) mack_q <= !sda_s;
        if (scl_fall) begin
          ack_ph_q <= 1'b0;
          if (mack_q) begin
            tx_q  <= rd_data;
            ptr_q <= ptr_q + 8'd1;
          end else begin
            stage_q <= ST_IGNORE;
          end
        end
      end
    end
  end

  assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (stage_q == ST_ADDR && bit_q == 4'd0));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (stage_q == ST_IDLE && !sda_oe));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_RDATA && $past(stage_q) == ST_RDATA && scl_s && $past(scl_s))
      |-> $stable(sda_oe));

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_idx,
  output logic [7:0]       rd_data,
  output logic [NREG*8-1:0] cfg_q
);

  localparam int         AW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG8 = 8'(NREG);

  logic [7:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reg_default(i);
    end else if (wr_en && wr_idx < NREG8) begin
      mem[wr_idx[AW-1:0]] <= merge_write(mem[wr_idx[AW-1:0]], wr_data,
                                         reg_romask(int'(wr_idx)));
    end
  end

  assign rd_data = (rd_idx < NREG8) ? mem[rd_idx[AW-1:0]] : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_q[g*8 +: 8] = mem[g];

    assert_ro_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mem[g] & reg_romask(g)));
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG        = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_xfer_fsm #(.NREG(NREG)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  smb_reg_bank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .cfg_q   (cfg_q)
  );

endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;

  localparam int NREG = 18;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] cfg_q;
  assign sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [NREG];

  smb_cfg_slave #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_q(cfg_q));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ro_of(input int i);
    if (i == 8)  return 8'h0F;
    if (i == 15) return 8'hF8;
    return 8'h00;
  endfunction

  function automatic logic [7:0] def_of(input int i);
    if (i == 2) return 8'hFF;
    if (i == 3) return 8'h3F;
    if (i == 8) return 8'h08;
    return 8'h00;
  endfunction

  task automatic model_write(input int i, input logic [7:0] d);
    if (i < NREG) model[i] = (model[i] & ro_of(i)) | (d & ~ro_of(i));
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, $sformatf("reg%0d", i), {24'h0, cfg_q[i*8 +: 8]}, {24'h0, model[i]});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(3*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit zh, output bit ack);
    if (zh) sda_m = b[7];
    for (int i = 7; i >= 0; i--) begin
      if (!zh) sda_m = b[i];
      tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
      if (zh) sda_m = (i > 0) ? b[i-1] : 1'b1;
      tick(Q);
    end
    sda_m = 1'b1;
    tick(Q); scl_m = 1'b1; tick(Q); ack = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_byte(input string req, input logic [7:0] off, input logic [7:0] d,
                         input bit zh);
    bit a;
    bus_start();
    send_byte(8'hD2, zh, a); check(req, "addr ack", {31'h0, a}, 1);
    send_byte(8'h80 | off, zh, a); check(req, "cmd ack", {31'h0, a}, 1);
    send_byte(d, zh, a); check(req, "data ack", {31'h0, a}, 1);
    bus_stop();
    model_write(int'(off), d);
  endtask

  task automatic rd_byte(input string req, input logic [7:0] off, output logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hD2, 0, a); check(req, "addr ack", {31'h0, a}, 1);
    send_byte(8'h80 | off, 0, a); check(req, "cmd ack", {31'h0, a}, 1);
    bus_start();
    send_byte(8'hD3, 0, a); check(req, "read addr ack", {31'h0, a}, 1);
    recv_byte(d, 0);
    bus_stop();
  endtask

  // R7: defaults after reset
  task automatic t_reset();
    check_all("R7");
    check("R7", "sda idle", {31'h0, sda_oe}, 0);
  endtask

  // R2 and R3: single register write then read back
  task automatic t_byte_rw();
    logic [7:0] d;
    wr_byte("R2", 8'd5, 8'hA5, 0);
    check_all("R2");
    rd_byte("R3", 8'd5, d);
    check("R3", "read reg5", {24'h0, d}, 32'hA5);
    rd_byte("R3", 8'd2, d);
    check("R3", "read reg2", {24'h0, d}, 32'hFF);
  endtask

  // R1: foreign address is ignored
  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte(8'hA4, 0, a); check("R1", "foreign addr nak", {31'h0, a}, 0);
    send_byte(8'h86, 0, a); check("R1", "no ack after foreign", {31'h0, a}, 0);
    send_byte(8'h77, 0, a); check("R1", "no ack data", {31'h0, a}, 0);
    bus_stop();
    check_all("R1");
  endtask

  // R4: block write with surplus bytes
  task automatic t_block_write();
    bit a;
    logic [7:0] vals [6];
    vals = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    bus_start();
    send_byte(8'hD2, 0, a); check("R4", "addr ack", {31'h0, a}, 1);
    send_byte(8'h00, 0, a); check("R4", "cmd ack", {31'h0, a}, 1);
    send_byte(8'h04, 0, a); check("R4", "count ack", {31'h0, a}, 1);
    for (int i = 0; i < 6; i++) begin
      send_byte(vals[i], 0, a);
      check("R4", $sformatf("data%0d ack", i), {31'h0, a}, 1);
      if (i < 4) model_write(i, vals[i]);
    end
    bus_stop();
    check_all("R4");
  endtask

  // R5: block read, count then registers upward
  task automatic t_block_read();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, 0, a); check("R5", "addr ack", {31'h0, a}, 1);
    send_byte(8'h00, 0, a); check("R5", "cmd ack", {31'h0, a}, 1);
    bus_start();
    send_byte(8'hD3, 0, a); check("R5", "read addr ack", {31'h0, a}, 1);
    recv_byte(d, 1);
    check("R5", "count byte", {24'h0, d}, NREG);
    for (int i = 0; i < 6; i++) begin
      recv_byte(d, i < 5);
      check("R5", $sformatf("block reg%0d", i), {24'h0, d}, {24'h0, model[i]});
    end
    bus_stop();
    check("R5", "released after nak", {31'h0, sda_oe}, 0);
  endtask

  // R6: read-only bits hold
  task automatic t_readonly();
    logic [7:0] d;
    wr_byte("R6", 8'd8, 8'hF5, 0);
    wr_byte("R6", 8'd15, 8'hFF, 0);
    check("R6", "reg8", {24'h0, cfg_q[8*8 +: 8]}, 32'hF8);
    check("R6", "reg15", {24'h0, cfg_q[15*8 +: 8]}, 32'h07);
    rd_byte("R6", 8'd8, d);
    check("R6", "read reg8", {24'h0, d}, 32'hF8);
  endtask

  // R9: index beyond the bank
  task automatic t_out_of_range();
    logic [7:0] d;
    wr_byte("R9", 8'd20, 8'h55, 0);
    check_all("R9");
    rd_byte("R9", 8'd20, d);
    check("R9", "read idx20", {24'h0, d}, 32'h00);
  endtask

  // R8: stop in the middle of a data byte
  task automatic t_stop_abort();
    bit a;
    logic [7:0] b = 8'hC3;
    bus_start();
    send_byte(8'hD2, 0, a); check("R8", "addr ack", {31'h0, a}, 1);
    send_byte(8'h87, 0, a); check("R8", "cmd ack", {31'h0, a}, 1);
    for (int i = 7; i >= 4; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    bus_stop();
    check_all("R8");
    wr_byte("R8", 8'd7, 8'h3C, 0);
    check("R8", "reg7 after abort", {24'h0, cfg_q[7*8 +: 8]}, 32'h3C);
  endtask

  // R2: SDA changes in the same cycle as the SCL fall
  task automatic t_zero_hold();
    logic [7:0] d;
    wr_byte("R2", 8'd9, 8'h6B, 1);
    check_all("R2");
    rd_byte("R3", 8'd9, d);
    check("R3", "read reg9", {24'h0, d}, 32'h6B);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = def_of(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_byte_rw();
    t_bad_addr();
    t_block_write();
    t_block_read();
    t_readonly();
    t_out_of_range();
    t_stop_abort();
    t_zero_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule